// File: doc/BRIEF.md
# Parallel Transmit Unpacker with Idle Bus Value

This block takes bytes from a valid/ready byte stream and puts them on a 16-bit parallel output bus, a lane group at a time. The lane width is picked per frame: 16, 8, 4, 2 or 1 bits. A frame starts on a start pulse while the block is idle. It carries a programmed number of bytes and closes with a one-cycle end-of-frame pulse. Outside a frame, and during any cycle where the stream has run dry, the bus shows a programmable idle word.

For 4-, 2- and 1-bit lanes, each byte is split either from its most significant end or from its least significant end. A valid strobe can be enabled to mark data cycles. A clock-enable output can be gated so that the outgoing transmit clock only runs while data is on the bus. Two sticky interrupt events are kept, each with an enable mask, a masked status and a write-one clear: a stream underrun during a frame, and frame completion.

The controller has four states. IDLE waits for start. FETCH waits for a byte and also gathers the first byte of a 16-bit pair. SEND puts one lane group per cycle on the bus. DONE produces the end-of-frame pulse. The transitions are:
- IDLE to FETCH on start with a nonzero length.
- IDLE to DONE on start with zero length.
- FETCH to SEND when a byte completes a word.
- FETCH stays in FETCH on the first byte of a pair, or while no byte arrives.
- SEND stays in SEND on further beats of a byte, or when the next byte is taken on the last beat.
- SEND to FETCH when the next byte is missing or opens a new pair.
- SEND to DONE after the last beat of the last byte.
- DONE to IDLE always.

Top module: `ptx_unpack`

## Requirements
- R1: A start pulse in IDLE with nonzero `byte_len` begins a frame. Exactly `byte_len` bytes are taken from the stream. After the last lane group of the last byte, `eof` is high for exactly one cycle.
- R2: Width codes are: 000 = 16 bits, 001 = 8, 010 = 4, 011 = 2, 100 = 1. Codes 101 to 111 act as 8 bits. Each byte gives 8/width bus cycles, with the lane group on `bus_data[width-1:0]` and all upper bits zero. In 8-bit and narrower modes, back-to-back bytes stream with no gap.
- R3: For 4-, 2- and 1-bit widths, `lsb_first`=0 sends each byte starting from bit 7. `lsb_first`=1 sends it starting from bit 0. Width and order are latched at start.
- R4: In 16-bit mode, bytes are paired: the first byte goes on bits 7:0 and the second on bits 15:8. A lone final byte goes out with bits 15:8 zero.
- R5: Whenever no lane group is being sent (idle, waiting for a byte, end of frame), `bus_data` equals `idle_val`.
- R6: With `valid_en`=1, `bus_valid` is high exactly in the cycles that carry frame data. With `valid_en`=0, `bus_valid` stays low.
- R7: With `gate_en`=1, `clk_en` is high only in cycles that carry frame data. With `gate_en`=0, `clk_en` is always high.
- R8: `tx_ready` is high only in IDLE. A start or length change during a frame is ignored, and `tx_ready` is low during the `eof` cycle.
- R9: A start with `byte_len`=0 gives an `eof` pulse on the next cycle, with no data cycles and no byte taken.
- R10: A cycle in FETCH without `s_valid` sets the underrun event, which is interrupt bit 0. The cycle of `eof` sets the completion event, which is interrupt bit 1.
- R11: Raw interrupt bits are sticky until a `int_clr` bit clears them; a set in the same cycle wins. `int_st` = `int_raw` & `int_ena`, and `irq` is the OR of `int_st`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, honoured in IDLE only |
| byte_len | input | LEN_W | Bytes per frame |
| width_code | input | 3 | Lane width selection |
| lsb_first | input | 1 | Narrow-width unpack order |
| idle_val | input | 16 | Bus value when not sending |
| valid_en | input | 1 | Enables the data-valid strobe |
| gate_en | input | 1 | Enables gating of the clock enable |
| int_ena | input | 2 | Interrupt enable mask |
| int_clr | input | 2 | Write-one clear of raw interrupt bits |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| bus_data | output | 16 | Parallel output bus |
| bus_valid | output | 1 | Data-valid strobe |
| clk_en | output | 1 | Enable for the outgoing transmit clock |
| tx_ready | output | 1 | Ready for a new start |
| eof | output | 1 | End-of-frame pulse |
| int_raw | output | 2 | Raw sticky interrupt bits |
| int_st | output | 2 | Masked interrupt status |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with the default 16-bit length counter. Random frames stay under 21 bytes, so every width code, both orders and the odd-length 16-bit case all come up within one short run. Random stream stalls bring the underrun path and the wait-state idle value within reach. Directed frames cover the zero-length start, an undefined width code, a restart attempt during a frame, and each mask and clear combination of the interrupt bits.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND,
        ST_DONE
    } ptx_state_e;

    localparam logic [2:0] WC_16 = 3'b000;
    localparam logic [2:0] WC_8  = 3'b001;
    localparam logic [2:0] WC_4  = 3'b010;
    localparam logic [2:0] WC_2  = 3'b011;
    localparam logic [2:0] WC_1  = 3'b100;

    // lane bits per bus cycle; undefined codes behave as 8
    function automatic logic [3:0] lane_bits(input logic [2:0] code);
        case (code)
            WC_4:    lane_bits = 4'd4;
            WC_2:    lane_bits = 4'd2;
            WC_1:    lane_bits = 4'd1;
            default: lane_bits = 4'd8;
        endcase
    endfunction

    // index of the last beat of a byte (beats - 1)
    function automatic logic [2:0] last_beat_idx(input logic [2:0] code);
        case (code)
            WC_4:    last_beat_idx = 3'd1;
            WC_2:    last_beat_idx = 3'd3;
            WC_1:    last_beat_idx = 3'd7;
            default: last_beat_idx = 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/ptx_slice.sv
module ptx_slice
    import ptx_pkg::*;
(
    input  logic [BUS_W-1:0]  word,
    input  logic [2:0]        code,
    input  logic              lsb_first,
    output logic [BUS_W-1:0]  lane,
    output logic [BYTE_W-1:0] rest
);
    localparam int PAD_W = BUS_W - BYTE_W;

    logic [3:0]        k;
    logic [BYTE_W-1:0] mask;
    logic [BYTE_W-1:0] low;

    always_comb begin
        k    = lane_bits(code);
        mask = BYTE_W'((9'd1 << k) - 9'd1);
        low  = word[BYTE_W-1:0];
        lane = {{PAD_W{1'b0}}, low};
        rest = low;
        if (code == WC_16) begin
            lane = word;
        end else if (k < 4'd8) begin
            if (lsb_first) begin
                lane = {{PAD_W{1'b0}}, low & mask};
                rest = low >> k;
            end else begin
                lane = {{PAD_W{1'b0}}, low >> (4'd8 - k)};
                rest = low << k;
            end
        end
    end
endmodule

// File: rtl/ptx_irq.sv
module ptx_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ena,
    output logic [N-1:0] raw,
    output logic [N-1:0] st,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      raw[i] <= 1'b0;
            else if (set[i]) raw[i] <= 1'b1;
            else if (clr[i]) raw[i] <= 1'b0;
        end

        // R11
        raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (raw[i] && !clr[i]) |=> raw[i]);
        // R11
        raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> raw[i]);
    end

    always_comb begin
        st  = raw & ena;
        irq = |st;
    end
endmodule

// File: rtl/ptx_unpack.sv
module ptx_unpack
    import ptx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  byte_len,
    input  logic [2:0]        width_code,
    input  logic              lsb_first,
    input  logic [BUS_W-1:0]  idle_val,
    input  logic              valid_en,
    input  logic              gate_en,
    input  logic [1:0]        int_ena,
    input  logic [1:0]        int_clr,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic [BUS_W-1:0]  bus_data,
    output logic              bus_valid,
    output logic              clk_en,
    output logic              tx_ready,
    output logic              eof,
    output logic [1:0]        int_raw,
    output logic [1:0]        int_st,
    output logic              irq
);
    localparam int PAD_W = BUS_W - BYTE_W;

    ptx_state_e        state_q, state_d;
    logic [LEN_W-1:0]  cnt_q;
    logic [BUS_W-1:0]  word_q;
    logic [BYTE_W-1:0] hold_q;
    logic              half_q;
    logic [2:0]        beat_q;
    logic [2:0]        code_q;
    logic              lsb_q;

    logic              last_beat, more, take, is16, pair_first, sending;
    logic [BUS_W-1:0]  lane;
    logic [BYTE_W-1:0] rest;

    always_comb begin
        last_beat  = (beat_q == 3'd0);
        more       = (cnt_q != '0);
        is16       = (code_q == WC_16);
        pair_first = is16 && !half_q && (cnt_q > LEN_W'(1));
        s_ready    = (state_q == ST_FETCH) ||
                     ((state_q == ST_SEND) && last_beat && more);
        take       = s_ready && s_valid;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = (byte_len == '0) ? ST_DONE : ST_FETCH;
            ST_FETCH: if (take)  state_d = pair_first ? ST_FETCH : ST_SEND;
            ST_SEND: begin
                if (last_beat) begin
                    if (!more)     state_d = ST_DONE;
                    else if (take) state_d = pair_first ? ST_FETCH : ST_SEND;
                    else           state_d = ST_FETCH;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // datapath: byte counter, word register, beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            word_q <= '0;
            hold_q <= '0;
            half_q <= 1'b0;
            beat_q <= 3'd0;
            code_q <= WC_16;
            lsb_q  <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                cnt_q  <= byte_len;
                code_q <= width_code;
                lsb_q  <= lsb_first;
                half_q <= 1'b0;
                beat_q <= 3'd0;
            end
        end else if (take) begin
            cnt_q <= cnt_q - LEN_W'(1);
            if (pair_first) begin
                hold_q <= s_data;
                half_q <= 1'b1;
            end else begin
                word_q <= (is16 && half_q) ? {s_data, hold_q} : {{PAD_W{1'b0}}, s_data};
                half_q <= 1'b0;
                beat_q <= last_beat_idx(code_q);
            end
        end else if (state_q == ST_SEND && !last_beat) begin
            word_q[BYTE_W-1:0] <= rest;
            beat_q             <= beat_q - 3'd1;
        end
    end

    ptx_slice u_slice (
        .word      (word_q),
        .code      (code_q),
        .lsb_first (lsb_q),
        .lane      (lane),
        .rest      (rest)
    );

    // outputs
    always_comb begin
        sending   = (state_q == ST_SEND);
        bus_data  = sending ? lane : idle_val;
        bus_valid = sending && valid_en;
        clk_en    = !gate_en || sending;
        tx_ready  = (state_q == ST_IDLE);
        eof       = (state_q == ST_DONE);
    end

    ptx_irq #(.N(2)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({eof, (state_q == ST_FETCH) && !s_valid}),
        .clr   (int_clr),
        .ena   (int_ena),
        .raw   (int_raw),
        .st    (int_st),
        .irq   (irq)
    );

    // R1
    no_overread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (cnt_q != '0));
    // R8
    ready_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> tx_ready);
    // R5
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (bus_data == idle_val));
    // R2
    narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && code_q == WC_1) |-> (bus_data[BUS_W-1:1] == '0));
endmodule

// File: tb/sim_ptx_unpack.sv
`timescale 1ns/1ps
module sim_ptx_unpack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] byte_len = '0;
    logic [2:0]  width_code = '0;
    logic        lsb_first = 1'b0;
    logic [15:0] idle_val = '0;
    logic        valid_en = 1'b0;
    logic        gate_en = 1'b0;
    logic [1:0]  int_ena = '0;
    logic [1:0]  int_clr = '0;
    logic [7:0]  s_data = '0;
    logic        s_valid = 1'b0;
    logic        s_ready, bus_valid, clk_en, tx_ready, eof, irq;
    logic [15:0] bus_data;
    logic [1:0]  int_raw, int_st;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0]  bytes [64];
    logic [15:0] exp_q [1024];
    int          nexp;

    always #4 clk = ~clk;

    ptx_unpack u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic int wbits(input int code);
        case (code)
            0: return 16;
            2: return 4;
            3: return 2;
            4: return 1;
            default: return 8;
        endcase
    endfunction

    task automatic build_exp(input int len, input int code, input bit ord);
        int w = wbits(code);
        nexp = 0;
        if (w == 16) begin
            for (int i = 0; i < len; i += 2) begin
                exp_q[nexp] = (i + 1 < len) ? {bytes[i+1], bytes[i]} : {8'h00, bytes[i]};
                nexp++;
            end
        end else begin
            for (int i = 0; i < len; i++) begin
                for (int j = 0; j < 8 / w; j++) begin
                    int sh = ord ? w * j : 8 - w * (j + 1);
                    exp_q[nexp] = 16'((bytes[i] >> sh) & ((1 << w) - 1));
                    nexp++;
                end
            end
        end
    endtask

    task automatic run_frame(input int len, input int code, input bit ord, input int stall,
                             input bit ven, input bit gen, input int restart_at);
        int idx = 0, got = 0, cyc = 0;
        bit hs = 0, done = 0, beat;
        for (int i = 0; i < len; i++) bytes[i] = 8'($urandom);
        build_exp(len, code, ord);
        @(negedge clk);
        chk(tx_ready == 1'b1, "R8 ready before start", 32'(tx_ready), 1);
        byte_len = 16'(len); width_code = 3'(code); lsb_first = ord;
        valid_en = ven; gate_en = gen; start = 1'b1; s_valid = 1'b0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start    = (cyc == restart_at);
            byte_len = (cyc == restart_at) ? 16'(len + 3) : 16'(len);
            if (hs) idx++;
            s_valid = (cyc > 1) && (idx < len) && (($urandom % 100) >= stall);
            s_data  = (idx < len) ? bytes[idx] : 8'hxx;
            #1;
            hs   = s_valid && s_ready;
            beat = ven ? bus_valid : clk_en;
            if (beat) begin
                if (got < nexp)
                    chk(bus_data == exp_q[got], "R2 R3 R4 beat", 32'(bus_data), 32'(exp_q[got]));
                else
                    chk(1'b0, "R1 extra beat", 32'(got), 32'(nexp));
                got++;
            end else if (ven) begin
                chk(bus_data == idle_val, "R5 idle value", 32'(bus_data), 32'(idle_val));
            end
            if (!ven) chk(bus_valid == 1'b0, "R6 valid disabled", 32'(bus_valid), 0);
            if (gen && ven) chk(clk_en == bus_valid, "R7 gated clock", 32'(clk_en), 32'(bus_valid));
            if (!gen) chk(clk_en == 1'b1, "R7 ungated clock", 32'(clk_en), 1);
            if (!eof) chk(tx_ready == 1'b0, "R8 busy", 32'(tx_ready), 0);
            if (eof) begin
                done = 1;
                chk(tx_ready == 1'b0, "R8 not ready at eof", 32'(tx_ready), 0);
            end
        end
        s_valid = 1'b0; start = 1'b0;
        chk(done, "R1 eof seen", 32'(done), 1);
        chk(got == nexp, "R1 R9 beat count", 32'(got), 32'(nexp));
        chk(idx + (hs ? 1 : 0) == len, "R1 bytes taken", 32'(idx + (hs ? 1 : 0)), 32'(len));
        @(negedge clk);
        chk(eof == 1'b0, "R1 eof single cycle", 32'(eof), 0);
        chk(tx_ready == 1'b1, "R8 ready after", 32'(tx_ready), 1);
        chk(bus_data == idle_val, "R5 idle after frame", 32'(bus_data), 32'(idle_val));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle_val = 16'hA5C3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready == 1'b1, "R8 reset ready", 32'(tx_ready), 1);
        chk(bus_data == idle_val, "R5 reset bus", 32'(bus_data), 32'(idle_val));
        chk(eof == 1'b0, "R1 reset eof", 32'(eof), 0);
        chk(int_raw == 2'b00, "R11 reset raw", 32'(int_raw), 0);
        chk(irq == 1'b0, "R11 reset irq", 32'(irq), 0);

        // directed corners
        run_frame(0, 1, 0, 0, 1, 1, 0);          // R9 zero length
        run_frame(5, 0, 0, 0, 1, 1, 0);          // R4 odd length, 16-bit
        run_frame(4, 4, 0, 0, 1, 0, 0);          // R3 1-bit MSB first
        run_frame(4, 4, 1, 0, 1, 1, 0);          // R3 1-bit LSB first
        run_frame(3, 6, 0, 0, 1, 1, 0);          // R2 undefined code as 8-bit
        run_frame(6, 2, 1, 0, 0, 1, 0);          // R6 valid disabled
        run_frame(6, 1, 0, 0, 1, 1, 3);          // R8 restart ignored

        // random frames
        for (int f = 0; f < 40; f++) begin
            bit ven = 1'($urandom);
            idle_val = 16'($urandom);
            run_frame($urandom % 21, $urandom % 5, 1'($urandom), $urandom % 50,
                      ven, ven ? 1'($urandom) : 1'b1,
                      (($urandom % 2) == 0) ? 0 : int'(2 + $urandom % 8));
        end

        // R10 R11 interrupt events, mask and clear
        @(negedge clk); int_clr = 2'b11;
        @(negedge clk); int_clr = 2'b00;
        @(negedge clk);
        chk(int_raw == 2'b00, "R11 cleared", 32'(int_raw), 0);
        run_frame(3, 1, 0, 0, 1, 1, 0);
        int_ena = 2'b10;
        @(negedge clk);
        chk(int_raw == 2'b11, "R10 underrun and eof raw", 32'(int_raw), 3);
        chk(int_st == 2'b10, "R11 masked status", 32'(int_st), 2);
        chk(irq == 1'b1, "R11 irq on", 32'(irq), 1);
        int_clr = 2'b10;
        @(negedge clk); int_clr = 2'b00;
        chk(int_raw == 2'b01, "R11 clear eof bit", 32'(int_raw), 1);
        chk(irq == 1'b0, "R11 irq masked", 32'(irq), 0);
        int_ena = 2'b01;
        @(negedge clk);
        chk(irq == 1'b1, "R11 irq underrun", 32'(irq), 1);
        repeat (3) @(negedge clk);
        chk(int_raw == 2'b01, "R11 sticky", 32'(int_raw), 1);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule